// File: doc/BRIEF.md
# Eight-Input Nested Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt signal for a processor. Each line has a bit in three 8-bit registers: a pending-request register, an in-service register and a mask register. A rising edge on a request line records a pending request. The block compares the best unmasked pending request with the best level already in service. It raises its interrupt output only when the pending request ranks strictly higher. Because of this rule, service routines can nest.

When the processor acknowledges, the block does three things in the same cycle. It presents an 8-bit vector built from a programmable base and the winning level. It clears that level's pending bit. It sets that level's in-service bit. One level can be marked, through parameters, as the port of a subordinate controller. When that level wins, the block drives a 3-bit cascade code instead of a vector.

A small register bus gives software four addresses:
- 0: the mask, read and write.
- 1: the pending-request register, read only.
- 2: the in-service register. A read returns it. A write issues an end-of-interrupt.
- 3: the vector base, in bits 7:3.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset the mask reads 0xFF, the pending and in-service registers read 0x00, and `int_req` is low.
- R2: A 0-to-1 transition on `irq_in[n]` sets pending bit n. A line held high does not set the bit again after an acknowledge has cleared it. Writes to address 1 do not change the pending register.
- R3: A mask bit of 1 keeps its level from raising `int_req`, but its pending bit is still recorded. A mask bit of 0 enables the level. Mask bit n maps to input n.
- R4: Among unmasked pending levels, the lowest index wins. Level 0 has the highest priority.
- R5: `int_req` is high only when the winning pending level is numerically lower than the lowest set in-service bit. A pending level equal to or below the top in-service level never raises it.
- R6: An acknowledge (`int_ack` high while `int_req` is high) has these effects:
  - In that cycle, `vec_valid` is high and `vec_out` equals {base[4:0], level[2:0]}.
  - In the following cycle, the level's pending bit is clear and its in-service bit is set.
- R7: Several in-service bits may be set at once when a higher level preempts a lower one.
- R8: A write to address 2 clears only the lowest-index set in-service bit. With no bit set, it has no effect.
- R9: When the winning level equals the cascade level (default 2), an acknowledge drives `cas_valid` high and `cas_code` equal to the level, and `vec_valid` stays low.
- R10: An `int_ack` pulse while `int_req` is low produces no vector and no cascade code, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_ack | input | 1 | Processor acknowledge, one cycle per acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector during an acknowledge, zero otherwise |
| vec_valid | output | 1 | `vec_out` is valid this cycle |
| cas_code | output | 3 | Level routed to the subordinate controller |
| cas_valid | output | 1 | `cas_code` is valid this cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |

## Verification
Errors in the in-service register show up at the ports in one of two ways:
- `int_req` fails to rise after an end-of-interrupt.
- `int_req` rises for a level that should be blocked.

Both are visible on the cycle after the faulty update, because the output depends only on registered state. Errors in the pending register show up as the wrong vector at the next acknowledge, or as a stale bit when address 1 is read. The bench therefore reads both registers back after every acknowledge and every end-of-interrupt. A scoreboard compares each acknowledge against the vector or cascade code predicted from the priority rules.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_IN = 8;
    localparam int LVL_W  = $clog2(NUM_IN);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - LVL_W;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_REQ  = 2'd1,
        REG_SVC  = 2'd2,
        REG_BASE = 2'd3
    } reg_addr_e;

    // Lowest set index wins.
    function automatic pick_t find_top(input logic [NUM_IN-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.lvl = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.lvl = LVL_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [NUM_IN-1:0] lvl_to_bit(input logic [LVL_W-1:0] l);
        return {{(NUM_IN-1){1'b0}}, 1'b1} << l;
    endfunction
endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              clr_en,
    input  logic [LVL_W-1:0]  clr_lvl,
    output logic [NUM_IN-1:0] req_q
);
    logic [NUM_IN-1:0] prev_q;
    logic [NUM_IN-1:0] rise_w;
    logic [NUM_IN-1:0] clr_vec;

    assign rise_w  = irq_in & ~prev_q;
    assign clr_vec = clr_en ? lvl_to_bit(clr_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= irq_in;
            req_q  <= (req_q & ~clr_vec) | rise_w;
        end
    end

    // R2
    rise_sets_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_w != '0) |=> ((req_q & $past(rise_w)) == $past(rise_w)));

    // R6
    ack_clears_req_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !rise_w[clr_lvl]) |=> !req_q[$past(clr_lvl)]);
endmodule

// File: rtl/irqc_svc_bank.sv
module irqc_svc_bank
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [LVL_W-1:0]  set_lvl,
    input  logic              eoi,
    output logic [NUM_IN-1:0] svc_q
);
    pick_t             top_w;
    logic [NUM_IN-1:0] set_vec;
    logic [NUM_IN-1:0] clr_vec;

    always_comb begin
        top_w   = find_top(svc_q);
        set_vec = set_en ? lvl_to_bit(set_lvl) : '0;
        clr_vec = (eoi && top_w.hit) ? lvl_to_bit(top_w.lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= (svc_q & ~clr_vec) | set_vec;
    end

    // R6
    ack_sets_svc_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> svc_q[$past(set_lvl)]);

    // R8
    eoi_pops_one_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !set_en && svc_q != '0) |=>
        ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R8
    eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !set_en && svc_q == '0) |=> (svc_q == '0));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NUM_IN-1:0] req_q,
    input  logic [NUM_IN-1:0] mask_q,
    input  logic [NUM_IN-1:0] svc_q,
    output logic              int_req,
    output pick_t             win
);
    pick_t svc_top;

    always_comb begin
        win     = find_top(req_q & ~mask_q);
        svc_top = find_top(svc_q);
        int_req = win.hit && (!svc_top.hit || (win.lvl < svc_top.lvl));
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter bit CASC_EN  = 1'b1,
    parameter int CASC_LVL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              int_ack,
    output logic              int_req,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_valid,
    output logic [LVL_W-1:0]  cas_code,
    output logic              cas_valid,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [NUM_IN-1:0] mask_q;
    logic [BASE_W-1:0] base_q;
    logic [NUM_IN-1:0] req_q;
    logic [NUM_IN-1:0] svc_q;
    pick_t             win;
    logic              ack_go;
    logic              is_casc;
    logic              wr_en;
    logic              eoi;
    reg_addr_e         addr_e;

    assign addr_e = reg_addr_e'(bus_addr);
    assign wr_en  = bus_sel & bus_we;
    assign eoi    = wr_en && (addr_e == REG_SVC);
    assign ack_go = int_ack & int_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            base_q <= '0;
        end else if (wr_en) begin
            if (addr_e == REG_MASK) mask_q <= bus_wdata[NUM_IN-1:0];
            if (addr_e == REG_BASE) base_q <= bus_wdata[DATA_W-1:LVL_W];
        end
    end

    always_comb begin
        case (addr_e)
            REG_MASK: bus_rdata = mask_q;
            REG_REQ:  bus_rdata = req_q;
            REG_SVC:  bus_rdata = svc_q;
            default:  bus_rdata = {base_q, {LVL_W{1'b0}}};
        endcase
    end

    irqc_req_bank u_req (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .clr_en  (ack_go),
        .clr_lvl (win.lvl),
        .req_q   (req_q)
    );

    irqc_svc_bank u_svc (
        .clk     (clk),
        .rst     (rst),
        .set_en  (ack_go),
        .set_lvl (win.lvl),
        .eoi     (eoi),
        .svc_q   (svc_q)
    );

    irqc_arbiter u_arb (
        .req_q   (req_q),
        .mask_q  (mask_q),
        .svc_q   (svc_q),
        .int_req (int_req),
        .win     (win)
    );

    generate
        if (CASC_EN) begin : g_casc
            assign is_casc = (win.lvl == LVL_W'(CASC_LVL));
        end else begin : g_no_casc
            assign is_casc = 1'b0;
        end
    endgenerate

    assign vec_valid = ack_go & ~is_casc;
    assign vec_out   = vec_valid ? {base_q, win.lvl} : '0;
    assign cas_valid = ack_go & is_casc;
    assign cas_code  = cas_valid ? win.lvl : '0;

    // R3
    masked_never_raise_chk: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((req_q & ~mask_q) != '0));

    // R9
    one_output_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vec_valid, cas_valid}));

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_req && !eoi) |=> $stable(svc_q));

    // R1
    reset_mask_chk: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '1 && svc_q == '0));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [2:0] cas_code;
    logic       cas_valid;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [1:0] kind;   // 0 none, 1 vector, 2 cascade
        logic [7:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .int_ack(int_ack),
        .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid),
        .cas_code(cas_code), .cas_valid(cas_valid),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && int_ack) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected acknowledge", 8'd1, 8'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                case (e.kind)
                    2'd0: chk("R10 idle ack outputs", {6'd0, vec_valid, cas_valid}, 8'd0);
                    2'd1: begin
                        chk("R6 vec_valid", {7'd0, vec_valid}, 8'd1);
                        chk("R4 R6 vector", vec_out, e.val);
                    end
                    default: begin
                        chk("R9 cas_valid/vec_valid", {6'd0, cas_valid, vec_valid}, 8'd2);
                        chk("R9 cascade code", {5'd0, cas_code}, e.val);
                    end
                endcase
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read_chk(input logic [1:0] a, input logic [7:0] expv, input string tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, expv);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(posedge clk); #1;
        irq_in = v;
        @(posedge clk); #1;
    endtask

    task automatic int_chk(input logic expv, input string tag);
        @(negedge clk);
        chk(tag, {7'd0, int_req}, {7'd0, expv});
    endtask

    task automatic do_ack(input logic [1:0] kind, input logic [7:0] val);
        exp_t e;
        e.kind = kind;
        e.val  = val;
        @(posedge clk); #1;
        exp_q.push_back(e);
        int_ack = 1'b1;
        @(posedge clk); #1;
        int_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        bus_read_chk(2'd0, 8'hFF, "R1 mask after reset");
        bus_read_chk(2'd1, 8'h00, "R1 pending after reset");
        bus_read_chk(2'd2, 8'h00, "R1 in-service after reset");
        int_chk(1'b0, "R1 int_req after reset");

        bus_write(2'd3, 8'hA8);
        bus_read_chk(2'd3, 8'hA8, "R6 vector base readback");

        // R3 masked request recorded but silent
        bus_write(2'd0, 8'h20);
        set_irq(8'h20);
        bus_read_chk(2'd1, 8'h20, "R2 edge sets pending bit 5");
        int_chk(1'b0, "R3 masked level 5 silent");
        bus_write(2'd0, 8'h00);
        int_chk(1'b1, "R3 unmasked level 5 raises");

        // R4 priority and R6 acknowledge
        set_irq(8'h28);
        do_ack(2'd1, 8'hAB);
        bus_read_chk(2'd2, 8'h08, "R6 in-service bit 3 set");
        bus_read_chk(2'd1, 8'h20, "R6 pending bit 3 cleared");
        int_chk(1'b0, "R5 lower level 5 blocked by 3");

        // R7 nesting
        set_irq(8'h2A);
        int_chk(1'b1, "R5 level 1 preempts 3");
        do_ack(2'd1, 8'hA9);
        bus_read_chk(2'd2, 8'h0A, "R7 nested in-service 1 and 3");
        bus_read_chk(2'd1, 8'h20, "R2 held line not relatched");

        // R10 idle acknowledge
        do_ack(2'd0, 8'h00);
        bus_read_chk(2'd2, 8'h0A, "R10 in-service unchanged");
        bus_read_chk(2'd1, 8'h20, "R10 pending unchanged");

        // R8 end-of-interrupt
        bus_write(2'd2, 8'h00);
        bus_read_chk(2'd2, 8'h08, "R8 eoi clears bit 1 only");
        int_chk(1'b0, "R5 level 5 still blocked");
        bus_write(2'd2, 8'h00);
        bus_read_chk(2'd2, 8'h00, "R8 eoi clears bit 3");
        int_chk(1'b1, "R8 pending 5 signalled after eoi");
        do_ack(2'd1, 8'hAD);
        bus_write(2'd2, 8'h00);
        bus_write(2'd2, 8'h00);
        bus_read_chk(2'd2, 8'h00, "R8 eoi on empty no effect");

        // R2 pending not writable
        bus_write(2'd1, 8'hFF);
        bus_read_chk(2'd1, 8'h00, "R2 write to pending ignored");

        // R9 cascade level
        set_irq(8'h00);
        set_irq(8'h04);
        do_ack(2'd2, 8'h02);
        bus_read_chk(2'd2, 8'h04, "R9 cascade level in service");

        // R5 equal level does not preempt
        set_irq(8'h00);
        set_irq(8'h04);
        bus_read_chk(2'd1, 8'h04, "R2 new edge on level 2");
        int_chk(1'b0, "R5 equal level blocked");
        bus_write(2'd2, 8'h00);
        int_chk(1'b1, "R5 equal level after eoi");
        do_ack(2'd2, 8'h02);
        bus_write(2'd2, 8'h00);

        // R4 simultaneous arrivals
        set_irq(8'h00);
        set_irq(8'h50);
        do_ack(2'd1, 8'hAC);
        bus_read_chk(2'd1, 8'h40, "R4 level 6 left pending");

        repeat (2) @(posedge clk);
        chk("R6 scoreboard drained", 8'(exp_q.size()), 8'd0);
        summary();
        $finish;
    end
endmodule